// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time Counter

This block keeps a free-running 64-bit count of nanoseconds for a precision time protocol clock. It runs on the selected reference clock. On every enabled edge a programmable 32-bit addend is added to a 32-bit fractional accumulator. Only the edges that carry out of the accumulator count as nominal ticks. Each tick adds the programmed tick period, in nanoseconds, to the time counter.

Because the addend is a fraction of 2^32, the servo can trim the effective rate in very fine steps. The nominal addend is ceil(2^32 / (f_ref / f_nominal)). The ratio f_ref / f_nominal must be above 1.0, so that a carry occurs on fewer than every edge. The largest upward trim, in parts per billion, is 1e9 × (ratio − 1) − 1.

A divider counts nominal ticks and produces a prescaled output clock. A one-cycle tick strobe and the current time feed downstream pulse generators. A 2-bit code is held and driven out to steer an external clock multiplexer. Software can load a new time at any moment.

Top module: `ptp_tcnt`

## Requirements
- R1: After reset:
  - time_ns is 0, tick is 0 and out_clk is 1.
  - The accumulator residue is 0.
  - The addend is 0x999999A4, the tick period is 10 ns, the prescale is 100 and clk_sel is 1.
- R2: On every clock edge with enable high, the addend is added to the 32-bit accumulator modulo 2^32.
  - When that sum carries out, tick is 1 in the following cycle.
  - On that same edge, time_ns grows by the tick period that was in force before the edge.
  - Without a carry (and without a load), time_ns is unchanged and tick is 0.
- R3: With the residue at 0 and addend 0x80000000, exactly one of every two enabled edges produces a tick.
- R4: A new addend written on an edge is first used on the following edge. The accumulator residue is kept across the write.
- R5: While enable is low, there is no accumulation and no tick, and time_ns holds unless a time load occurs.
- R6: When tload_we is high on an edge, time_ns becomes tload_val. If that edge also carries, time_ns becomes tload_val plus the tick period.
- R7: time_ns wraps modulo 2^64.
- R8: The output divider works on the effective prescale P:
  - P is the programmed prescale, except that values 0 and 1 act as 2.
  - The divider counts ticks from 0 to P−1 and then returns to 0.
  - out_clk is 1 while the count is below floor(P/2).
  - A prescale write resets the count to 0 on that edge.
- R9: clk_sel drives the 2-bit source code last written, from the cycle after the write.
- R10: A write (cfg_we high) is decoded by cfg_addr. Writes are ignored during reset. The fields are:

  | cfg_addr | Field | Bits taken from cfg_wdata |
  |---|---|---|
  | 0 | Addend | [31:0] |
  | 1 | Tick period | [7:0] |
  | 2 | Prescale | [15:0] |
  | 3 | Clock-source code | [1:0] |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gates accumulation and ticking |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | 32 | Configuration write data |
| tload_we | input | 1 | Time load strobe |
| tload_val | input | 64 | Time value to load |
| time_ns | output | 64 | Current time in nanoseconds |
| tick | output | 1 | One-cycle strobe per accumulator carry |
| out_clk | output | 1 | Prescaled output clock |
| clk_sel | output | 2 | Reference source select code |

## Verification
The checker watches the following on every cycle:
- A tick advances time by exactly the prior period.
- With no tick and no load, the time is frozen.
- A disabled edge never ticks.
- A load puts the loaded value, plus the period when a tick coincides, on time_ns.
- clk_sel follows its write.

Only the bench scenarios can show the rest:
- The exact carry pattern produced by a given addend and residue.
- That an addend change waits one edge without clearing the residue.
- The divider waveforms for odd, even and degenerate prescales.
- Wrap-around of the 64-bit time.

// File: rtl/ptp_tcnt_pkg.sv
package ptp_tcnt_pkg;
   typedef enum logic [1:0] {
      FLD_ADDEND   = 2'd0,
      FLD_PERIOD   = 2'd1,
      FLD_PRESCALE = 2'd2,
      FLD_CLKSRC   = 2'd3
   } fld_e;
endpackage

// File: rtl/ptp_tcnt_regs.sv
module ptp_tcnt_regs #(
   parameter int CFG_W = 32,
   parameter int ACC_W = 32,
   parameter int PER_W = 8,
   parameter int PRSC_W = 16,
   parameter int SEL_W = 2,
   parameter logic [ACC_W-1:0] RST_ADDEND = 32'h999999A4,
   parameter logic [PER_W-1:0] RST_PERIOD = 8'd10,
   parameter logic [PRSC_W-1:0] RST_PRSC = 16'd100,
   parameter logic [SEL_W-1:0] RST_SEL = 2'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [CFG_W-1:0]  wdata,
   output logic [ACC_W-1:0]  addend_q,
   output logic [PER_W-1:0]  period_q,
   output logic [PRSC_W-1:0] prsc_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic              prsc_wr
);
   import ptp_tcnt_pkg::*;

   logic [3:0] hit;

   // Decode of the write strobe into one enable per field.
   genvar gi;
   generate
      for (gi = 0; gi < 4; gi++) begin : g_dec
         assign hit[gi] = we && (addr == gi[1:0]);
      end
   endgenerate

   assign prsc_wr = hit[FLD_PRESCALE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addend_q <= RST_ADDEND;
         period_q <= RST_PERIOD;
         prsc_q   <= RST_PRSC;
         sel_q    <= RST_SEL;
      end else begin
         if (hit[FLD_ADDEND])   addend_q <= wdata[ACC_W-1:0];
         if (hit[FLD_PERIOD])   period_q <= wdata[PER_W-1:0];
         if (hit[FLD_PRESCALE]) prsc_q   <= wdata[PRSC_W-1:0];
         if (hit[FLD_CLKSRC])   sel_q    <= wdata[SEL_W-1:0];
      end
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;
endmodule

// File: rtl/ptp_tcnt_accum.sv
module ptp_tcnt_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] addend,
   output logic             carry
);
   logic [ACC_W-1:0] resid_q;
   logic [ACC_W:0]   sum;

   assign sum   = {1'b0, resid_q} + {1'b0, addend};
   assign carry = en & sum[ACC_W];

   always_ff @(posedge clk) begin
      if (!rst_n)  resid_q <= '0;
      else if (en) resid_q <= sum[ACC_W-1:0];
   end
endmodule

// File: rtl/ptp_tcnt_time.sv
module ptp_tcnt_time #(
   parameter int TIME_W = 64,
   parameter int PER_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carry,
   input  logic [PER_W-1:0]  period,
   input  logic              ld,
   input  logic [TIME_W-1:0] ld_val,
   output logic [TIME_W-1:0] time_q,
   output logic              tick_q
);
   logic [TIME_W-1:0] base;
   logic [TIME_W-1:0] step;

   // Load first, then apply any carry from the same edge.
   assign base = ld ? ld_val : time_q;
   assign step = carry ? {{(TIME_W-PER_W){1'b0}}, period} : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
         tick_q <= 1'b0;
      end else begin
         time_q <= base + step;
         tick_q <= carry;
      end
   end
endmodule

// File: rtl/ptp_tcnt_prsc.sv
module ptp_tcnt_prsc #(
   parameter int PRSC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carry,
   input  logic              restart,
   input  logic [PRSC_W-1:0] prsc,
   output logic              out_clk
);
   localparam logic [PRSC_W-1:0] MIN_DIV = PRSC_W'(2);

   logic [PRSC_W-1:0] eff;
   logic [PRSC_W-1:0] half;
   logic [PRSC_W-1:0] cnt_q;

   assign eff = (prsc < MIN_DIV) ? MIN_DIV : prsc;

   generate
      if (PRSC_W > 1) begin : g_half
         assign half = {1'b0, eff[PRSC_W-1:1]};
      end else begin : g_half1
         assign half = eff;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (carry)   cnt_q <= (cnt_q >= eff - 1'b1) ? '0 : cnt_q + 1'b1;
   end

   assign out_clk = (cnt_q < half);
endmodule

// File: rtl/ptp_tcnt.sv
module ptp_tcnt #(
   parameter int TIME_W = 64,
   parameter int ACC_W = 32,
   parameter int CFG_W = 32,
   parameter int PER_W = 8,
   parameter int PRSC_W = 16,
   parameter int SEL_W = 2,
   parameter logic [ACC_W-1:0] RST_ADDEND = 32'h999999A4,
   parameter logic [PER_W-1:0] RST_PERIOD = 8'd10,
   parameter logic [PRSC_W-1:0] RST_PRSC = 16'd100,
   parameter logic [SEL_W-1:0] RST_SEL = 2'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              tload_we,
   input  logic [TIME_W-1:0] tload_val,
   output logic [TIME_W-1:0] time_ns,
   output logic              tick,
   output logic              out_clk,
   output logic [SEL_W-1:0]  clk_sel
);
   generate
      if (ACC_W < 2 || ACC_W > CFG_W) begin : g_bad_acc
         $error("ACC_W must be within 2..CFG_W");
      end
      if (PER_W > CFG_W || PER_W >= TIME_W) begin : g_bad_per
         $error("PER_W must fit in CFG_W and be below TIME_W");
      end
      if (PRSC_W < 2 || PRSC_W > CFG_W) begin : g_bad_prsc
         $error("PRSC_W must be within 2..CFG_W");
      end
      if (SEL_W < 1 || SEL_W > CFG_W) begin : g_bad_sel
         $error("SEL_W must be within 1..CFG_W");
      end
   endgenerate

   logic [ACC_W-1:0]  addend_w;
   logic [PER_W-1:0]  period_w;
   logic [PRSC_W-1:0] prsc_w;
   logic              prsc_wr_w;
   logic              carry_w;

   ptp_tcnt_regs #(
      .CFG_W(CFG_W), .ACC_W(ACC_W), .PER_W(PER_W), .PRSC_W(PRSC_W), .SEL_W(SEL_W),
      .RST_ADDEND(RST_ADDEND), .RST_PERIOD(RST_PERIOD),
      .RST_PRSC(RST_PRSC), .RST_SEL(RST_SEL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .addend_q(addend_w), .period_q(period_w), .prsc_q(prsc_w),
      .sel_q(clk_sel), .prsc_wr(prsc_wr_w)
   );

   ptp_tcnt_accum #(.ACC_W(ACC_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .en(enable), .addend(addend_w), .carry(carry_w)
   );

   ptp_tcnt_time #(.TIME_W(TIME_W), .PER_W(PER_W)) u_time (
      .clk(clk), .rst_n(rst_n), .carry(carry_w), .period(period_w),
      .ld(tload_we), .ld_val(tload_val), .time_q(time_ns), .tick_q(tick)
   );

   ptp_tcnt_prsc #(.PRSC_W(PRSC_W)) u_prsc (
      .clk(clk), .rst_n(rst_n), .carry(carry_w), .restart(prsc_wr_w),
      .prsc(prsc_w), .out_clk(out_clk)
   );
endmodule

// File: rtl/ptp_tcnt_chk.sv
module ptp_tcnt_chk #(
   parameter int TIME_W = 64,
   parameter int CFG_W = 32,
   parameter int PER_W = 8,
   parameter int SEL_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              cfg_we,
   input logic [1:0]        cfg_addr,
   input logic [CFG_W-1:0]  cfg_wdata,
   input logic              tload_we,
   input logic [TIME_W-1:0] tload_val,
   input logic [TIME_W-1:0] time_ns,
   input logic              tick,
   input logic [SEL_W-1:0]  clk_sel,
   input logic [PER_W-1:0]  period_w
);
   logic armed;
   logic [TIME_W-1:0] per_ext;

   assign per_ext = {{(TIME_W-PER_W){1'b0}}, period_w};

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2: a tick means time moved by exactly the old period
   a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && tick && !$past(tload_we)) |-> (time_ns == $past(time_ns) + $past(per_ext)));

   // R2: no tick and no load leaves time untouched
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !tick && !$past(tload_we)) |-> $stable(time_ns));

   // R5: a disabled edge produces no tick
   a_r5_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(enable)) |-> !tick);

   // R6: load value lands, plus a coincident period
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(tload_we)) |->
         (time_ns == $past(tload_val) + (tick ? $past(per_ext) : '0)));

   // R9: the source code follows its write
   a_r9_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(cfg_we) && $past(cfg_addr) == 2'd3) |->
         (clk_sel == $past(cfg_wdata[SEL_W-1:0])));
endmodule

bind ptp_tcnt ptp_tcnt_chk #(
   .TIME_W(TIME_W), .CFG_W(CFG_W), .PER_W(PER_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .tload_we(tload_we), .tload_val(tload_val),
   .time_ns(time_ns), .tick(tick), .clk_sel(clk_sel), .period_w(period_w)
);

// File: tb/ptp_tcnt_tb_top.sv
module ptp_tcnt_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic        tload_we = 1'b0;
   logic [63:0] tload_val = 64'd0;
   logic [63:0] time_ns;
   logic        tick;
   logic        out_clk;
   logic [1:0]  clk_sel;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   bit live = 0;

   always #10 clk = ~clk;

   ptp_tcnt dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .tload_we(tload_we), .tload_val(tload_val),
      .time_ns(time_ns), .tick(tick), .out_clk(out_clk), .clk_sel(clk_sel)
   );

   // Behavioural reference model
   longint unsigned m_time;
   longint unsigned m_acc, m_add, m_per, m_prsc, m_cnt, m_sel;
   bit m_tick;

   function automatic longint unsigned eff_div(longint unsigned p);
      return (p < 2) ? 2 : p;
   endfunction

   always @(posedge clk) begin
      longint unsigned s, t;
      bit c;
      if (!rst_n) begin
         m_time = 0; m_acc = 0; m_add = 64'h999999A4; m_per = 10;
         m_prsc = 100; m_cnt = 0; m_sel = 1; m_tick = 0;
      end else begin
         c = 0;
         if (enable) begin
            s = m_acc + m_add;
            c = (s >= 64'h1_0000_0000);
            m_acc = s & 64'hFFFF_FFFF;
         end
         t = tload_we ? tload_val : m_time;
         if (c) t = t + m_per;
         m_time = t;
         m_tick = c;
         if (cfg_we && cfg_addr == 2'd2) m_cnt = 0;
         else if (c) m_cnt = (m_cnt >= eff_div(m_prsc) - 1) ? 0 : m_cnt + 1;
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: m_add  = cfg_wdata;
               2'd1: m_per  = cfg_wdata & 32'hFF;
               2'd2: m_prsc = cfg_wdata & 32'hFFFF;
               default: m_sel = cfg_wdata & 32'h3;
            endcase
         end
      end
   end

   task automatic chk(string req, longint unsigned act, longint unsigned exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Compare every cycle, shortly after the edge
   always @(posedge clk) begin
      #2;
      if (live) begin
         chk("R2 time", time_ns, m_time);
         chk("R2 tick", tick, m_tick);
         chk("R8 out_clk", out_clk, (m_cnt < eff_div(m_prsc) / 2) ? 1 : 0);
         chk("R9 clk_sel", clk_sel, m_sel);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ld(logic [63:0] v);
      @(negedge clk);
      tload_we = 1'b1; tload_val = v;
      @(negedge clk);
      tload_we = 1'b0;
   endtask

   initial begin
      longint unsigned snap;
      int ticks;
      cyc(3);
      live = 1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 time", time_ns, 0);
      chk("R1 tick", tick, 0);
      chk("R1 out_clk", out_clk, 1);
      chk("R1 clk_sel", clk_sel, 1);

      // R2: default addend
      enable = 1'b1;
      cyc(40);
      chk("R2 moved", (time_ns > 0) ? 1 : 0, 1);

      // R4: addend change keeps residue
      wr(2'd0, 32'h4000_0000);
      cyc(16);

      // R5: enable low freezes everything
      enable = 1'b0;
      @(negedge clk);
      snap = time_ns;
      ticks = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         ticks += tick;
      end
      chk("R5 frozen time", time_ns, snap);
      chk("R5 no ticks", ticks, 0);

      // R6: load while idle and while ticking
      ld(64'h1234_5678_9ABC_DEF0);
      chk("R6 load idle", time_ns, 64'h1234_5678_9ABC_DEF0);
      wr(2'd0, 32'hFFFF_FFFF);
      enable = 1'b1;
      cyc(4);
      ld(64'h0000_0000_0000_1000);
      chk("R6 load+tick", time_ns, m_time);

      // R7: wrap modulo 2^64
      ld(64'hFFFF_FFFF_FFFF_FFF8);
      cyc(3);
      chk("R7 wrapped", (time_ns < 64'd100) ? 1 : 0, 1);

      // R10 and R8: period and prescale fields
      wr(2'd1, 32'hAB07);
      wr(2'd2, 32'hFFFF_0004);
      cyc(30);
      wr(2'd2, 32'd3);
      cyc(30);
      wr(2'd2, 32'd1);
      cyc(20);
      wr(2'd2, 32'd0);
      cyc(10);

      // R9: source codes
      wr(2'd3, 32'd0);
      chk("R9 sel0", clk_sel, 0);
      wr(2'd3, 32'hFE);
      chk("R9 sel2", clk_sel, 2);
      wr(2'd3, 32'd3);
      chk("R9 sel3", clk_sel, 3);

      // R3: half addend from zero residue
      enable = 1'b0;
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      wr(2'd0, 32'h8000_0000);
      enable = 1'b1;
      ticks = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         ticks += tick;
      end
      chk("R3 tick count", ticks, 10);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule